// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a pixel clock into the raster timing a parallel LCD panel expects: a horizontal sync, a vertical sync, a data-enable window, the current pixel column and row, and a one-cycle pulse at the start of vertical blanking for the interrupt logic. Software describes the mode through a small bank of 32-bit write-only registers. Every count in them is stored minus one, except the vertical total, which is stored as twice the line count. Both back porches are measured from the leading edge of their sync pulse to the end of the line or frame.

The generator is a three-state machine. `ST_IDLE` holds every output quiet while either enable is clear. Transition `go_delay` leaves idle when both enables are set and the start delay is non-zero. Transition `go_scan` leaves idle straight to scanning when the delay is zero. `ST_DELAY` burns a programmed number of whole blank lines. Transition `delay_done` moves to `ST_SCAN` after the last of those lines. `ST_SCAN` walks the raster frame after frame. Transition `drop` returns to idle from either busy state as soon as an enable is cleared. Timing words are copied into a shadow set when scanning starts and at every frame wrap, so a write in mid-frame only changes the next frame. Interlaced modes are treated as progressive.

Top module: `disp_tg`

## Requirements
- R1: After reset de, vblank, pix_x and pix_y are 0, and hsync and vsync are 0, their inactive level with no inversion.
- R2: Word index 0 bit 31 is the global enable and word index 1 bit 31 is the channel enable. Scanning (de or vblank ever 1) starts only when both are set.
- R3: Word indices hold: 1 bits [8:4] start delay D; 2 bits [27:16] active width-1 and [11:0] active height-1; 3 bits [31:16] horizontal total-1 and [15:0] horizontal back porch-1; 4 bits [31:16] twice the line total and [15:0] vertical back porch-1; 5 bits [31:16] hsync width-1 and [15:0] vsync width-1; 6 bit 25 hsync invert and bit 24 vsync invert.
- R4: The cycle after the write that completes both enables, the block spends D whole lines blank. de first rises 1 + D*Htotal clock edges after that write's edge, which is 1 edge when D is 0.
- R5: During scanning pix_x counts 0 to Htotal-1 and then wraps. pix_y advances at each wrap of pix_x and returns to 0 after line (word 4 upper half / 2) - 1.
- R6: de is 1 exactly when pix_x is below the active width and pix_y is below the active height.
- R7: Before inversion, hsync is 1 for pix_x in [Htotal-HBP, Htotal-HBP+HSW).
- R8: Before inversion, vsync is 1 for pix_y in [Lines-VBP, Lines-VBP+VSW).
- R9: Inversion bits flip the corresponding sync output, and the inactive level in idle too.
- R10: vblank is a one-cycle pulse at pix_x = 0 on row pix_y = active height.
- R11: A timing or polarity write made during a frame leaves that frame unchanged and takes effect from the next frame.
- R12: Clearing an enable returns the block to idle on the next clock edge: de 0, syncs at their inactive level, counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word index |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Active pixel window |
| pix_x | output | 12 | Current column |
| pix_y | output | 12 | Current row |
| vblank | output | 1 | Start-of-vertical-blank pulse |

## Verification
The assertions assume a sane mode: a horizontal total of at least two pixels, active sizes no larger than the totals, and back porches no longer than the totals. Under those conditions the counters wrap and the vblank pulse cannot repeat on back-to-back cycles. The stimulus programs the full mode before it sets either enable. Every mode it uses has more lines than active rows and porches that fit inside their totals. Writes made while scanning only touch polarity and active size, and both stay within those limits.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;
    localparam int TG_CW  = 12;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_GLOBAL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CHAN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SIZE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_HTIM   = 3'd3;
    localparam logic [ADDR_W-1:0] A_VTIM   = 3'd4;
    localparam logic [ADDR_W-1:0] A_SYNC   = 3'd5;
    localparam logic [ADDR_W-1:0] A_POL    = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SCAN  = 2'd2
    } tg_state_t;

    typedef struct packed {
        logic [TG_CW-1:0] hact_m1;
        logic [TG_CW-1:0] htot_m1;
        logic [TG_CW-1:0] hbp_m1;
        logic [TG_CW-1:0] hsw_m1;
        logic [TG_CW-1:0] vact_m1;
        logic [TG_CW-1:0] vtot2;
        logic [TG_CW-1:0] vbp_m1;
        logic [TG_CW-1:0] vsw_m1;
        logic             inv_h;
        logic             inv_v;
    } tg_timing_t;
endpackage

// File: rtl/disp_tg_regs.sv
module disp_tg_regs
    import disp_tg_pkg::*;
#(
    parameter int DLY_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               load,
    output logic               run,
    output logic [DLY_W-1:0]   start_dly,
    output tg_timing_t         shadow
);
    localparam int HI = 16;
    localparam int DLY_LSB = 4;

    logic       master_q;
    logic       chan_q;
    tg_timing_t live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q  <= 1'b0;
            chan_q    <= 1'b0;
            start_dly <= '0;
            live_q    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_GLOBAL: master_q <= wr_data[31];
                A_CHAN: begin
                    chan_q    <= wr_data[31];
                    start_dly <= wr_data[DLY_LSB +: DLY_W];
                end
                A_SIZE: begin
                    live_q.hact_m1 <= wr_data[HI +: TG_CW];
                    live_q.vact_m1 <= wr_data[0 +: TG_CW];
                end
                A_HTIM: begin
                    live_q.htot_m1 <= wr_data[HI +: TG_CW];
                    live_q.hbp_m1  <= wr_data[0 +: TG_CW];
                end
                A_VTIM: begin
                    live_q.vtot2  <= wr_data[HI +: TG_CW];
                    live_q.vbp_m1 <= wr_data[0 +: TG_CW];
                end
                A_SYNC: begin
                    live_q.hsw_m1 <= wr_data[HI +: TG_CW];
                    live_q.vsw_m1 <= wr_data[0 +: TG_CW];
                end
                A_POL: begin
                    live_q.inv_h <= wr_data[25];
                    live_q.inv_v <= wr_data[24];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (load) begin
            shadow <= live_q;
        end
    end

    assign run = master_q && chan_q;
endmodule

// File: rtl/disp_tg_fsm.sv
module disp_tg_fsm
    import disp_tg_pkg::*;
#(
    parameter int DLY_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DLY_W-1:0]  start_dly,
    input  tg_timing_t        tim,
    output tg_state_t         state,
    output logic [TG_CW-1:0]  hc,
    output logic [TG_CW-1:0]  vc,
    output logic              load
);
    tg_state_t        state_nx;
    logic [DLY_W-1:0] dl;
    logic [TG_CW-1:0] vlines_m1;
    logic             line_end;
    logic             frame_end;
    logic             delay_last;

    assign vlines_m1  = {1'b0, tim.vtot2[TG_CW-1:1]} - TG_CW'(1);
    assign line_end   = (hc == tim.htot_m1);
    assign frame_end  = line_end && (vc == vlines_m1);
    assign delay_last = ({1'b0, dl} + (DLY_W+1)'(1)) == {1'b0, start_dly};

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (run) state_nx = (start_dly == '0) ? ST_SCAN : ST_DELAY;
            end
            ST_DELAY: begin
                if (!run) state_nx = ST_IDLE;
                else if (line_end && delay_last) state_nx = ST_SCAN;
            end
            ST_SCAN: begin
                if (!run) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign load = run && ((state == ST_IDLE) || ((state == ST_SCAN) && frame_end));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || state == ST_IDLE) begin
            hc <= '0;
            vc <= '0;
            dl <= '0;
        end else if (state == ST_DELAY) begin
            vc <= '0;
            if (line_end) begin
                hc <= '0;
                dl <= dl + DLY_W'(1);
            end else begin
                hc <= hc + TG_CW'(1);
            end
        end else begin
            if (line_end) begin
                hc <= '0;
                vc <= frame_end ? '0 : vc + TG_CW'(1);
            end else begin
                hc <= hc + TG_CW'(1);
            end
        end
    end

    a_r12_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == ST_IDLE && hc == '0 && vc == '0));

    a_r5_x_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (hc <= tim.htot_m1));

    a_r5_x_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && run && !line_end) |=> (hc == $past(hc) + TG_CW'(1)));

    a_r4_delay_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY) |-> (vc == '0));
endmodule

// File: rtl/disp_tg_out.sv
module disp_tg_out
    import disp_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tg_state_t         state,
    input  logic [TG_CW-1:0]  hc,
    input  logic [TG_CW-1:0]  vc,
    input  tg_timing_t        tim,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              vblank
);
    logic             scan;
    logic [TG_CW-1:0] hs_start;
    logic [TG_CW:0]   hs_end;
    logic [TG_CW-1:0] vlines;
    logic [TG_CW-1:0] vs_start;
    logic [TG_CW:0]   vs_end;
    logic             hs_raw;
    logic             vs_raw;

    assign scan     = (state == ST_SCAN);
    assign hs_start = tim.htot_m1 - tim.hbp_m1;
    assign hs_end   = {1'b0, hs_start} + {1'b0, tim.hsw_m1} + (TG_CW+1)'(1);
    assign vlines   = {1'b0, tim.vtot2[TG_CW-1:1]};
    assign vs_start = vlines - tim.vbp_m1 - TG_CW'(1);
    assign vs_end   = {1'b0, vs_start} + {1'b0, tim.vsw_m1} + (TG_CW+1)'(1);

    always_comb begin
        hs_raw = scan && (hc >= hs_start) && ({1'b0, hc} < hs_end);
        vs_raw = scan && (vc >= vs_start) && ({1'b0, vc} < vs_end);
        hsync  = hs_raw ^ tim.inv_h;
        vsync  = vs_raw ^ tim.inv_v;
        de     = scan && (hc <= tim.hact_m1) && (vc <= tim.vact_m1);
        vblank = scan && (hc == '0) && ({1'b0, vc} == {1'b0, tim.vact_m1} + (TG_CW+1)'(1));
    end

    a_r10_vblank_outside_de: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |-> !de);

    a_r10_vblank_single: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> !vblank);

    a_r2_quiet_unless_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SCAN) |-> (!de && !vblank && hsync == tim.inv_h && vsync == tim.inv_v));
endmodule

// File: rtl/disp_tg.sv
module disp_tg
    import disp_tg_pkg::*;
#(
    parameter int DLY_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [11:0]       pix_x,
    output logic [11:0]       pix_y,
    output logic              vblank
);
    logic             run;
    logic             load;
    logic [DLY_W-1:0] start_dly;
    tg_timing_t       shadow;
    tg_state_t        state;
    logic [TG_CW-1:0] hc;
    logic [TG_CW-1:0] vc;

    disp_tg_regs #(.DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load), .run(run), .start_dly(start_dly),
        .shadow(shadow)
    );

    disp_tg_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .start_dly(start_dly),
        .tim(shadow), .state(state), .hc(hc), .vc(vc), .load(load)
    );

    disp_tg_out u_out (
        .clk(clk), .rst_n(rst_n), .state(state), .hc(hc), .vc(vc),
        .tim(shadow), .hsync(hsync), .vsync(vsync), .de(de), .vblank(vblank)
    );

    assign pix_x = hc;
    assign pix_y = vc;

    a_r11_shadow_holds_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !load) |=> $stable(shadow));
endmodule

// File: tb/disp_tg_bench.sv
module disp_tg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, vblank;
    logic [11:0] pix_x, pix_y;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    disp_tg u_disp_tg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .vblank(vblank)
    );

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called on a negedge where the design sits at column 0, row 0 of a frame.
    task automatic check_frame(input int hact, input int htot, input int hbp, input int hsw,
                               input int vact, input int vln, input int vbp, input int vsw,
                               input bit ih, input bit iv,
                               input bit do_wr, input int wr_at,
                               input logic [2:0] wa, input logic [31:0] wd);
        int hs0 = htot - hbp;
        int vs0 = vln - vbp;
        for (int i = 0; i < htot * vln; i++) begin
            int x = i % htot;
            int y = i / htot;
            check("R5 pix_x", pix_x, x);
            check("R5 pix_y", pix_y, y);
            check("R6 de", de, (x < hact && y < vact) ? 1 : 0);
            check("R7 R9 hsync", hsync, ((x >= hs0 && x < hs0 + hsw) ? 1 : 0) ^ ih);
            check("R8 R9 vsync", vsync, ((y >= vs0 && y < vs0 + vsw) ? 1 : 0) ^ iv);
            check("R10 vblank", vblank, (x == 0 && y == vact) ? 1 : 0);
            wr_en = do_wr && (i == wr_at);
            wr_addr = wa;
            wr_data = wd;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 de", de, 0);
        check("R1 vblank", vblank, 0);
        check("R1 hsync", hsync, 0);
        check("R1 vsync", vsync, 0);
        check("R1 pix_x", pix_x, 0);
        check("R1 pix_y", pix_y, 0);
    endtask

    task automatic t_program_mode;
        // R3: 8x4 active, 14 total, bp 4, hsw 2; 7 lines, vbp 2, vsw 1
        reg_write(3'd2, (32'd7 << 16) | 32'd3);
        reg_write(3'd3, (32'd13 << 16) | 32'd3);
        reg_write(3'd4, (32'd14 << 16) | 32'd1);
        reg_write(3'd5, (32'd1 << 16) | 32'd0);
        reg_write(3'd6, 32'd0);
    endtask

    task automatic t_gate;
        // R2: only global enable set, nothing may scan
        reg_write(3'd0, 32'h8000_0000);
        for (int i = 0; i < 40; i++) begin
            check("R2 de gated", de, 0);
            check("R2 vblank gated", vblank, 0);
            check("R2 pix_x gated", pix_x, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_start(input int d, input int htot);
        int n = 0;
        reg_write(3'd1, 32'h8000_0000 | (32'(d) << 4));
        while (!de && n < 600) begin
            @(negedge clk);
            n++;
        end
        check("R4 start latency", n, 1 + d * htot);
    endtask

    task automatic t_disable(input bit ih, input bit iv);
        reg_write(3'd1, 32'd0);
        @(negedge clk);
        check("R12 de", de, 0);
        check("R12 hsync", hsync, ih);
        check("R12 vsync", vsync, iv);
        check("R12 pix_x", pix_x, 0);
        check("R12 pix_y", pix_y, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_mode();
        t_gate();
        t_start(3, 14);
        check_frame(8, 14, 4, 2, 4, 7, 2, 1, 0, 0, 0, 0, 3'd0, 32'd0);
        // R11: polarity write mid-frame, seen next frame (R9)
        check_frame(8, 14, 4, 2, 4, 7, 2, 1, 0, 0, 1, 20, 3'd6, 32'h0300_0000);
        // R11: active size write mid-frame
        check_frame(8, 14, 4, 2, 4, 7, 2, 1, 1, 1, 1, 30, 3'd2, (32'd5 << 16) | 32'd3);
        check_frame(6, 14, 4, 2, 4, 7, 2, 1, 1, 1, 0, 0, 3'd0, 32'd0);
        t_disable(1, 1);
        t_start(0, 14);
        check_frame(6, 14, 4, 2, 4, 7, 2, 1, 1, 1, 0, 0, 3'd0, 32'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule